// File: doc/BRIEF.md
# Coherent NCO Lock-In Demodulator

This block drives a probe with a digital sine and measures the response coherently. One 32-bit phase accumulator advances by a programmable tuning word on every enabled clock. The top bits of its value give the excitation code sent to a DAC. The same value, plus a calibratable phase offset, gives the sine and cosine references used for demodulation.

Each valid signed response sample is multiplied by both references. The two products are summed over a window that always spans a whole number of excitation periods. Period boundaries are taken from accumulator wraparound.

When a window closes, the block publishes the in-phase and quadrature sums and pulses a done strobe. The sums then hold until the following window closes. A sticky flag tells firmware that a change to the tuning word or the window length has invalidated the stored phase calibration. The flag stays set until a new offset is written.

Top module: `lockin_demod`

## Requirements
- R1: While `enable` is high, the phase accumulator (reset value 0) grows by the tuning word on every clock, modulo 2^32. While `enable` is low it is held at 0. In each cycle, `excCode` is the sine code of the accumulator's current bits [31:22].
- R2: The sine code of a 10-bit address a is formed as follows:
  - Let k = a[7:0], and set kk = 255-k when a[8] is 1, otherwise kk = k.
  - The magnitude is floor(32767*kk*(512-kk)/65536).
  - The code is that magnitude negated when a[9] is 1.
  - The cosine code of a is the sine code of (a+256) mod 1024.
- R3: The reference address is bits [31:22] of (accumulator + phase offset) mod 2^32. The offset changes only the references and never `excCode`.
- R4: For each cycle inside a window with `sampleValid` high, the I sum gains sample*sine(ref) and the Q sum gains sample*cosine(ref). Samples presented while `sampleValid` is low add nothing.
- R5: A wrap cycle is the first cycle holding the accumulator value that follows a carry out of bit 31. After enable rises, every sample before the first wrap cycle is discarded. The first window opens in that wrap cycle and includes its sample.
- R6: A window closes at the N-th wrap cycle after it opened, where N is the window length. `resultDone` is high for one cycle, in the cycle after that closing wrap cycle. At the same point `iOut`/`qOut` take the sums over the window's cycles, from its opening wrap cycle up to and excluding the closing one. Those outputs hold until the next done. The closing wrap cycle opens the next window.
- R7: A window length of 0 behaves as a length of 1. The default length after reset is 1.
- R8: `calStale` is 1 after reset. It is set in the cycle after a tuning-word or window-length write. It is cleared in the cycle after a phase-offset write. When a setting write and an offset write share a cycle, the flag ends up set.
- R9: After reset, `iOut` and `qOut` are 0, `resultDone` is 0 and `excCode` is 0.
- R10: Lowering `enable` abandons any open window. After enable rises again, accumulation waits once more for the first wrap (R5). The published outputs keep their last values in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the accumulator and demodulation |
| cfgFreqWr | input | 1 | Tuning-word write strobe |
| cfgFreqData | input | 32 | Tuning word |
| cfgWinWr | input | 1 | Window-length write strobe |
| cfgWinData | input | 16 | Window length in excitation periods |
| cfgPhaseWr | input | 1 | Phase-offset write strobe |
| cfgPhaseData | input | 32 | Reference phase offset |
| sampleIn | input | 16 | Signed response sample |
| sampleValid | input | 1 | Marks sampleIn as valid |
| excCode | output | 16 | Signed excitation code for the DAC |
| iOut | output | 48 | Signed in-phase window sum |
| qOut | output | 48 | Signed quadrature window sum |
| resultDone | output | 1 | One-cycle pulse when new sums are published |
| calStale | output | 1 | Phase calibration needs refreshing |

## Verification
The hardest case to reach from the ports is a closing wrap cycle that does two jobs at once. It must publish the old sums and also seed the new window with its own sample, and this matters most when wraps come on consecutive cycles or very unevenly. The bench reaches it with tuning words that produce irregular period lengths, with a word of three quarters of full scale so that most cycles wrap, and with a window length of 0. It also drops `enable` in the middle of a window to force a fresh discard-and-arm sequence. A cycle-level model of the accumulator, written from the requirements, predicts every done pulse and every sum.

// File: rtl/lockin_pkg.sv
package lockin_pkg;
  localparam int PHASE_W = 32;
  localparam int LUT_W   = 10;
  localparam int QTR_W   = LUT_W - 2;
  localparam int QTR_N   = 1 << QTR_W;
  localparam int SAMP_W  = 16;
  localparam int PROD_W  = 2 * SAMP_W;
  localparam int ACC_W   = 48;
  localparam int WIN_W   = 16;
  localparam int AMP     = 32767;

  typedef struct packed {
    logic startWin;
    logic accum;
    logic publish;
  } ctrl_strobe_t;

  typedef enum logic {ST_ARM, ST_RUN} ctrl_state_t;

  // quarter-wave parabolic sine, mirrored and negated by the two top address bits
  function automatic logic signed [SAMP_W-1:0] sineCode(input logic [LUT_W-1:0] addr);
    logic [QTR_W-1:0] k;
    logic [31:0] sq;
    logic [47:0] scaled;
    logic signed [SAMP_W-1:0] mag;
    k = addr[QTR_W] ? ~addr[QTR_W-1:0] : addr[QTR_W-1:0];
    sq = 32'(k) * (32'(2 * QTR_N) - 32'(k));
    scaled = 48'(sq) * 48'(AMP);
    mag = SAMP_W'(scaled >> (2 * QTR_W));
    return addr[LUT_W-1] ? -mag : mag;
  endfunction
endpackage

// File: rtl/lockin_nco.sv
module lockin_nco
  import lockin_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int LW = LUT_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enable,
  input  logic [PW-1:0]            freqWord,
  input  logic [PW-1:0]            phaseOff,
  output logic signed [SAMP_W-1:0] excCode,
  output logic signed [SAMP_W-1:0] refSin,
  output logic signed [SAMP_W-1:0] refCos,
  output logic                     wrapFlag
);
  localparam int SHIFT = PW - LW;

  logic [PW-1:0] phaseAcc;
  logic [PW:0]   sum;
  logic [LW-1:0] refTop;
  logic signed [SAMP_W-1:0] refVal [2];

  assign sum = {1'b0, phaseAcc} + {1'b0, freqWord};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc <= '0;
      wrapFlag <= 1'b0;
    end else if (enable) begin
      phaseAcc <= sum[PW-1:0];
      wrapFlag <= sum[PW];
    end else begin
      phaseAcc <= '0;
      wrapFlag <= 1'b0;
    end
  end

  // excitation sees the raw accumulator, references see it shifted by the offset
  assign excCode = sineCode(phaseAcc[PW-1 -: LW]);
  assign refTop  = LW'((phaseAcc + phaseOff) >> SHIFT);

  for (genvar g = 0; g < 2; g++) begin : g_ref
    logic [LW-1:0] addr;
    assign addr      = refTop + LW'(g * QTR_N);
    assign refVal[g] = sineCode(addr);
  end

  assign refSin = refVal[0];
  assign refCos = refVal[1];

  // R1
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (phaseAcc == '0));

  // R5
  wrap_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable)) |-> (wrapFlag == (phaseAcc < $past(phaseAcc))));
endmodule

// File: rtl/lockin_ctrl.sv
module lockin_ctrl
  import lockin_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int WW = WIN_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          wrapFlag,
  input  logic          cfgFreqWr,
  input  logic [PW-1:0] cfgFreqData,
  input  logic          cfgWinWr,
  input  logic [WW-1:0] cfgWinData,
  input  logic          cfgPhaseWr,
  input  logic [PW-1:0] cfgPhaseData,
  output logic [PW-1:0] freqWord,
  output logic [PW-1:0] phaseOff,
  output ctrl_strobe_t  stb,
  output logic          resultDone,
  output logic          calStale
);
  logic [WW-1:0] winReg, winEff, cnt, cntInc, nCnt;
  ctrl_state_t   state, nState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqWord <= '0;
      winReg   <= WW'(1);
      phaseOff <= '0;
      calStale <= 1'b1;
    end else begin
      if (cfgFreqWr)  freqWord <= cfgFreqData;
      if (cfgWinWr)   winReg   <= cfgWinData;
      if (cfgPhaseWr) phaseOff <= cfgPhaseData;
      if (cfgFreqWr || cfgWinWr) calStale <= 1'b1;
      else if (cfgPhaseWr)       calStale <= 1'b0;
    end
  end

  assign winEff = (winReg == '0) ? WW'(1) : winReg;
  assign cntInc = cnt + WW'(1);

  always_comb begin
    stb    = '0;
    nState = state;
    nCnt   = cnt;
    if (!enable) begin
      nState = ST_ARM;
      nCnt   = '0;
    end else if (state == ST_ARM) begin
      if (wrapFlag) begin
        stb.startWin = 1'b1;
        nState       = ST_RUN;
        nCnt         = '0;
      end
    end else if (wrapFlag) begin
      if (cntInc == winEff) begin
        stb.publish  = 1'b1;
        stb.startWin = 1'b1;
        nCnt         = '0;
      end else begin
        stb.accum = 1'b1;
        nCnt      = cntInc;
      end
    end else begin
      stb.accum = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_ARM;
      cnt        <= '0;
      resultDone <= 1'b0;
    end else begin
      state      <= nState;
      cnt        <= nCnt;
      resultDone <= stb.publish;
    end
  end

  // R6
  win_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt < winEff);

  // R6
  done_on_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultDone |-> ($past(wrapFlag) && $past(enable)));

  // R8
  stale_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFreqWr || cfgWinWr) |=> calStale);

  // R8
  stale_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgPhaseWr && !cfgFreqWr && !cfgWinWr) |=> !calStale);
endmodule

// File: rtl/lockin_datapath.sv
module lockin_datapath
  import lockin_pkg::*;
#(
  parameter int SW = SAMP_W,
  parameter int AW = ACC_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t         stb,
  input  logic signed [SW-1:0] sampleIn,
  input  logic                 sampleValid,
  input  logic signed [SW-1:0] refSin,
  input  logic signed [SW-1:0] refCos,
  output logic signed [AW-1:0] iOut,
  output logic signed [AW-1:0] qOut
);
  localparam int PWID = 2 * SW;

  logic signed [SW-1:0] refs [2];
  logic signed [AW-1:0] res  [2];

  assign refs[0] = refSin;
  assign refs[1] = refCos;

  for (genvar g = 0; g < 2; g++) begin : g_chan
    logic signed [PWID-1:0] prod;
    logic signed [AW-1:0]   prodExt, acc;

    assign prod    = sampleIn * refs[g];
    assign prodExt = {{(AW-PWID){prod[PWID-1]}}, prod};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        acc    <= '0;
        res[g] <= '0;
      end else begin
        if (stb.publish) res[g] <= acc;
        if (stb.startWin)                  acc <= sampleValid ? prodExt : '0;
        else if (stb.accum && sampleValid) acc <= acc + prodExt;
      end
    end
  end

  assign iOut = res[0];
  assign qOut = res[1];

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.publish |=> ($stable(iOut) && $stable(qOut)));
endmodule

// File: rtl/lockin_demod.sv
module lockin_demod
  import lockin_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        cfgFreqWr,
  input  logic [31:0] cfgFreqData,
  input  logic        cfgWinWr,
  input  logic [15:0] cfgWinData,
  input  logic        cfgPhaseWr,
  input  logic [31:0] cfgPhaseData,
  input  logic [15:0] sampleIn,
  input  logic        sampleValid,
  output logic [15:0] excCode,
  output logic [47:0] iOut,
  output logic [47:0] qOut,
  output logic        resultDone,
  output logic        calStale
);
  logic [PHASE_W-1:0] freqWord, phaseOff;
  logic signed [SAMP_W-1:0] refSin, refCos, excS;
  logic wrapFlag;
  ctrl_strobe_t stb;
  logic signed [ACC_W-1:0] iS, qS;

  lockin_ctrl u_ctrl (
    .clk, .rstN, .enable, .wrapFlag,
    .cfgFreqWr, .cfgFreqData, .cfgWinWr, .cfgWinData,
    .cfgPhaseWr, .cfgPhaseData,
    .freqWord, .phaseOff, .stb, .resultDone, .calStale
  );

  lockin_nco u_nco (
    .clk, .rstN, .enable, .freqWord, .phaseOff,
    .excCode(excS), .refSin, .refCos, .wrapFlag
  );

  lockin_datapath u_dp (
    .clk, .rstN, .stb,
    .sampleIn($signed(sampleIn)), .sampleValid,
    .refSin, .refCos, .iOut(iS), .qOut(qS)
  );

  assign excCode = excS;
  assign iOut    = iS;
  assign qOut    = qS;
endmodule

// File: tb/lockin_demod_bench.sv
module lockin_demod_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, enable, cfgFreqWr, cfgWinWr, cfgPhaseWr, sampleValid;
  logic [31:0] cfgFreqData, cfgPhaseData;
  logic [15:0] cfgWinData, sampleIn, excCode;
  logic [47:0] iOut, qOut;
  logic resultDone, calStale;

  lockin_demod u_lockin_demod (.*);

  int nChecks = 0, nFail = 0;
  string tag = "";

  logic [31:0] mFreq = 0, mOff = 0, mPhase = 0;
  int mWin = 1, mCnt = 0;
  bit mWrap = 0, mRun = 0, expDone = 0, expStale = 1, chkExc = 0;
  longint mI = 0, mQ = 0, expI = 0, expQ = 0;
  int validMode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit pFw = 0, pWw = 0, pPw = 0;
  logic [31:0] pFv = 0, pPv = 0;
  logic [15:0] pWv = 0;

  task automatic check(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, tag, act, exp);
    end
  endtask

  function automatic longint sineRef(input logic [9:0] a);
    longint kk, m;
    kk = a[8] ? 255 - longint'(a[7:0]) : longint'(a[7:0]);
    m = (32767 * kk * (512 - kk)) / 65536;
    return a[9] ? -m : m;
  endfunction

  task automatic cycles(int n, bit en);
    for (int c = 0; c < n; c++) begin
      logic [31:0] sRef;
      logic [32:0] nxt;
      logic [15:0] sd;
      bit sv, pub, start, acc;
      longint pI, pQ;
      int eff;
      @(negedge clk);
      check("R6 done pulse", longint'(resultDone), longint'(expDone));
      if (expDone) begin
        check("R4 R6 I sum", longint'($signed(iOut)), expI);
        check("R4 R6 Q sum", longint'($signed(qOut)), expQ);
      end else begin
        check("R6 R10 I hold", longint'($signed(iOut)), expI);
      end
      check("R8 stale flag", longint'(calStale), longint'(expStale));
      if (chkExc)
        check("R1 R2 R3 excitation", longint'($signed(excCode)), sineRef(mPhase[31:22]));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sd = lfsr;
      sv = (validMode == 0) ? 1'b1 : (lfsr[0] ^ lfsr[3]);
      enable = en; sampleIn = sd; sampleValid = sv;
      cfgFreqWr = pFw; cfgFreqData = pFv;
      cfgWinWr = pWw; cfgWinData = pWv;
      cfgPhaseWr = pPw; cfgPhaseData = pPv;
      sRef = mPhase + mOff;
      pI = longint'($signed(sd)) * sineRef(sRef[31:22]);
      pQ = longint'($signed(sd)) * sineRef(sRef[31:22] + 10'd256);
      eff = (mWin == 0) ? 1 : mWin;
      pub = 0; start = 0; acc = 0;
      if (!en) begin mRun = 0; mCnt = 0; end
      else if (!mRun) begin if (mWrap) begin start = 1; mRun = 1; mCnt = 0; end end
      else if (mWrap) begin
        if (mCnt + 1 == eff) begin pub = 1; start = 1; mCnt = 0; end
        else begin acc = 1; mCnt++; end
      end else acc = 1;
      expDone = pub;
      if (pub) begin expI = mI; expQ = mQ; end
      if (start) begin mI = sv ? pI : 0; mQ = sv ? pQ : 0; end
      else if (acc && sv) begin mI += pI; mQ += pQ; end
      if (en) begin nxt = {1'b0, mPhase} + {1'b0, mFreq}; mPhase = nxt[31:0]; mWrap = nxt[32]; end
      else begin mPhase = 0; mWrap = 0; end
      if (pFw) mFreq = pFv;
      if (pWw) mWin = int'(pWv);
      if (pPw) mOff = pPv;
      if (pFw || pWw) expStale = 1; else if (pPw) expStale = 0;
      pFw = 0; pWw = 0; pPw = 0;
    end
  endtask

  task automatic setup(logic [31:0] f, logic [15:0] w, logic [31:0] o);
    pFw = 1; pFv = f; cycles(1, 0);
    pWw = 1; pWv = w; cycles(1, 0);
    pPw = 1; pPv = o; cycles(1, 0);
    cycles(1, 0);
  endtask

  initial begin
    #(8 * 200000);
    nFail++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    rstN = 0; enable = 0; cfgFreqWr = 0; cfgWinWr = 0; cfgPhaseWr = 0;
    cfgFreqData = 0; cfgWinData = 0; cfgPhaseData = 0; sampleIn = 0; sampleValid = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R9 reset state
    check("R9 iOut", longint'($signed(iOut)), 0);
    check("R9 qOut", longint'($signed(qOut)), 0);
    check("R9 done", longint'(resultDone), 0);
    check("R9 excCode", longint'($signed(excCode)), 0);
    check("R8 R9 stale at reset", longint'(calStale), 1);
    // R8 set/clear ordering, including simultaneous writes
    pPw = 1; pPv = 0; cycles(2, 0);
    pFw = 1; pFv = 32'h1000_0000; cycles(2, 0);
    pPw = 1; pPv = 0; cycles(2, 0);
    pWw = 1; pWv = 16'd1; pPw = 1; pPv = 0; cycles(2, 0);
    pPw = 1; pPv = 0; cycles(2, 0);
    // R1 R2 R4 R5: 16 samples per period, window of 1
    tag = "base"; chkExc = 1;
    cycles(120, 1);
    // R3: offset of a quarter turn, window 3, gapped samples
    cycles(2, 0);
    tag = "offset"; validMode = 1;
    setup(32'h1000_0000, 16'd3, 32'h4000_0000);
    cycles(200, 1);
    // irregular period length, then R10 disable mid-window and re-arm
    tag = "R10 irregular"; cycles(2, 0);
    setup(32'h0A3D_70A3, 16'd2, 32'h1234_5678);
    cycles(95, 1);
    cycles(20, 0);
    cycles(150, 1);
    // R7 window length 0 acts as 1
    tag = "R7 zero window"; validMode = 0; cycles(2, 0);
    setup(32'h0800_0000, 16'd0, 32'h2000_0000);
    cycles(250, 1);
    // wraps on most cycles: back-to-back window closings
    tag = "dense wraps"; validMode = 1; cycles(2, 0);
    setup(32'hC000_0000, 16'd5, 32'h0000_0000);
    cycles(60, 1);
    tag = "dense R7"; cycles(2, 0);
    setup(32'hC000_0000, 16'd0, 32'h0300_0000);
    cycles(30, 1);
    cycles(3, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule